// File: doc/BRIEF.md
# Mesh Barrier Synchronisation Network

This block gives a grid of ROWS x COLS cores a barrier network of its own, separate from any data fabric. A core that reaches a barrier pulses its `arrive` bit for one cycle and then stalls. When every core in the grid has arrived, the block pulses `resume` for all cores in the same cycle. Each core then continues past the barrier.

Detection has two levels. In each row, the core in column 0 hosts the row collector. The other cores in that row drive a shared request line toward it. The collector counts, in one cycle, how many of those lines are high, and it also records its own core's arrival. When a row is complete, its collector sends a one-cycle notice on a column line. The collector in row 0 also acts as the column collector. It counts the notices from rows 1 and up, and records its own row's completion. Wake-up runs the other way. The column collector raises its wake line to all row collectors. Each row collector then raises its row's wake line one cycle later.

Top module: `barrier_mesh`

## Requirements
- R1: While `rst_n` is low, and in the cycles after reset with no arrivals, `resume` is all zeros.
- R2: No bit of `resume` is raised while any core has not yet arrived at the current barrier.
- R3: Say the final missing `arrive` pulse is present in cycle k, so it is sampled at the clock edge that ends cycle k. Then `resume` is high in cycle k+4 and in no earlier cycle.
- R4: A release raises every bit of `resume` in the same cycle, for exactly one cycle.
- R5: Arrivals spread over many cycles accumulate. Several arrivals in one cycle, in one row or in several rows, are all counted in that cycle.
- R6: An `arrive` pulse from a core that is already waiting at the barrier is ignored. It does not count as an extra arrival and does not hasten or prevent the release.
- R7: A core may pulse `arrive` in the same cycle that `resume` is high. That pulse counts toward the next barrier, and the counters start that barrier from empty.
- R8: A row counts as complete only when all COLS-1 non-collector cores and the collector's own core (column 0) have arrived. The grid is complete only when row 0 and all other rows are complete.
- R9: Core index r*COLS+c maps to bit r*COLS+c of both `arrive` and `resume`. Column 0 of each row hosts that row's collector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. Its release must already be synchronous to `clk`. |
| arrive | input | ROWS*COLS | One-cycle arrival pulse per core |
| resume | output | ROWS*COLS | One-cycle release pulse per core |

## Verification
The bench goes after these corner cases:
- A collector core that arrives last, long after every other core. A design that treats a full slave count as a complete row would release early.
- Repeated `arrive` pulses from cores that are already waiting. A design that counts them would overshoot its counters and hang, or would release before the real final arrival.
- Barriers that start in the release cycle of the previous barrier. A design whose counters are not fully cleared would carry stale counts into the next barrier.
- Spread arrivals in random order. Any change in pipeline depth shows up as a release in the wrong cycle.

// File: rtl/barrier_mesh_pkg.sv
package barrier_mesh_pkg;
  // cycles from the cycle holding the final arrival to the release cycle
  localparam int unsigned WAKE_LATENCY = 4;

  // width that holds a count from 0 to n
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/barrier_mesh_popcnt.sv
module barrier_mesh_popcnt #(
  parameter  int unsigned W  = 4,
  localparam int unsigned CW = barrier_mesh_pkg::cnt_w(W)
) (
  input  logic [W-1:0]  bits,
  output logic [CW-1:0] total
);
  // sensed transmitter count on a shared line
  always_comb begin
    total = '0;
    for (int i = 0; i < int'(W); i++) total = total + CW'(bits[i]);
  end
endmodule

// File: rtl/barrier_mesh_port.sv
module barrier_mesh_port (
  input  logic clk,
  input  logic rst_n,
  input  logic arrive_i,
  input  logic wake_i,
  output logic tx_o,
  output logic resume_o
);
  logic waiting_q, waiting_d, resume_d;

  // a core already parked cannot transmit again
  assign tx_o = arrive_i & ~waiting_q;

  always_comb begin
    waiting_d = waiting_q;
    resume_d  = 1'b0;
    if (wake_i) begin
      waiting_d = 1'b0;
      resume_d  = waiting_q;
    end else if (tx_o) begin
      waiting_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waiting_q <= 1'b0;
      resume_o  <= 1'b0;
    end else begin
      waiting_q <= waiting_d;
      resume_o  <= resume_d;
    end
  end
endmodule

// File: rtl/barrier_mesh_row.sv
module barrier_mesh_row #(
  parameter int unsigned COLS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [COLS-1:0] row_tx,   // bit 0: collector's own core
  input  logic            vwake_i,
  output logic            vtx_o,
  output logic            hwake_o
);
  localparam int unsigned   CW  = barrier_mesh_pkg::cnt_w(COLS);
  localparam logic [COLS-1:0] OWN = COLS'(1);

  logic [CW-1:0] scnt_q, scnt_d, seen;
  logic          mcnt_q, mcnt_d, sent_q, sent_d, full, cnt_en;

  barrier_mesh_popcnt #(.W(COLS)) u_pc (.bits(row_tx & ~OWN), .total(seen));

  assign full  = (scnt_q == CW'(COLS - 1)) && mcnt_q;
  assign vtx_o = full && !sent_q;

  always_comb begin
    cnt_en = hwake_o | (|row_tx) | vtx_o;
    if (hwake_o) begin
      scnt_d = '0;
      mcnt_d = 1'b0;
      sent_d = 1'b0;
    end else begin
      scnt_d = scnt_q + seen;
      mcnt_d = mcnt_q | row_tx[0];
      sent_d = sent_q | vtx_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scnt_q  <= '0;
      mcnt_q  <= 1'b0;
      sent_q  <= 1'b0;
      hwake_o <= 1'b0;
    end else begin
      hwake_o <= vwake_i;
      if (cnt_en) begin
        scnt_q <= scnt_d;
        mcnt_q <= mcnt_d;
        sent_q <= sent_d;
      end
    end
  end
endmodule

// File: rtl/barrier_mesh_col.sv
module barrier_mesh_col #(
  parameter int unsigned ROWS = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ROWS-1:0] vs_tx,    // bit 0: row 0 completion
  output logic            vwake_o
);
  localparam int unsigned     CW  = barrier_mesh_pkg::cnt_w(ROWS);
  localparam logic [ROWS-1:0] OWN = ROWS'(1);

  logic [CW-1:0] vscnt_q, vscnt_d, seen;
  logic          vmcnt_q, vmcnt_d, cnt_en;

  barrier_mesh_popcnt #(.W(ROWS)) u_pc (.bits(vs_tx & ~OWN), .total(seen));

  assign vwake_o = (vscnt_q == CW'(ROWS - 1)) && vmcnt_q;

  always_comb begin
    cnt_en = vwake_o | (|vs_tx);
    if (vwake_o) begin
      vscnt_d = '0;
      vmcnt_d = 1'b0;
    end else begin
      vscnt_d = vscnt_q + seen;
      vmcnt_d = vmcnt_q | vs_tx[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vscnt_q <= '0;
      vmcnt_q <= 1'b0;
    end else if (cnt_en) begin
      vscnt_q <= vscnt_d;
      vmcnt_q <= vmcnt_d;
    end
  end
endmodule

// File: rtl/barrier_mesh.sv
module barrier_mesh #(
  parameter  int unsigned ROWS = 3,
  parameter  int unsigned COLS = 4,
  localparam int unsigned N    = ROWS * COLS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] arrive,
  output logic [N-1:0] resume
);
  logic [N-1:0]    tx;
  logic [ROWS-1:0] vtx, hwake;
  logic            vwake;

  for (genvar r = 0; r < int'(ROWS); r++) begin : g_row
    for (genvar c = 0; c < int'(COLS); c++) begin : g_core
      barrier_mesh_port u_port (
        .clk(clk), .rst_n(rst_n),
        .arrive_i(arrive[r*COLS+c]), .wake_i(hwake[r]),
        .tx_o(tx[r*COLS+c]), .resume_o(resume[r*COLS+c])
      );
    end
    barrier_mesh_row #(.COLS(COLS)) u_row (
      .clk(clk), .rst_n(rst_n),
      .row_tx(tx[r*COLS +: COLS]), .vwake_i(vwake),
      .vtx_o(vtx[r]), .hwake_o(hwake[r])
    );
  end

  barrier_mesh_col #(.ROWS(ROWS)) u_col (
    .clk(clk), .rst_n(rst_n), .vs_tx(vtx), .vwake_o(vwake)
  );
endmodule

// File: rtl/barrier_mesh_chk.sv
module barrier_mesh_chk #(
  parameter int unsigned ROWS = 3,
  parameter int unsigned COLS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ROWS*COLS-1:0] arrive,
  input logic [ROWS*COLS-1:0] resume
);
  logic [ROWS*COLS-1:0] seen_q;

  // cores that have pulsed arrive since the last release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else if (resume != '0) seen_q <= arrive;
    else seen_q <= seen_q | arrive;
  end

  always @(negedge clk) begin
    if (!rst_n) a_reset_quiet_r1: assert (resume == '0);
  end

  p_no_early_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (resume != '0) |-> (&seen_q));

  p_all_together_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (resume != '0) |-> (&resume));

  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (resume != '0) |=> (resume == '0));

  p_min_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (resume != '0) |=> (resume == '0) ##1 (resume == '0) ##1 (resume == '0));
endmodule

bind barrier_mesh barrier_mesh_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk(clk), .rst_n(rst_n), .arrive(arrive), .resume(resume)
);

// File: tb/sim_barrier_mesh.sv
module sim_barrier_mesh;
  localparam int ROWS = 3;
  localparam int COLS = 4;
  localparam int N = ROWS * COLS;
  localparam time PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] arrive = '0;
  logic [N-1:0] resume;
  int cyc = 0, n_chk = 0, n_fail = 0;
  bit done = 1'b0, live = 1'b0;
  int exp_q[$];

  barrier_mesh #(.ROWS(ROWS), .COLS(COLS)) u0 (
    .clk(clk), .rst_n(rst_n), .arrive(arrive), .resume(resume)
  );

  always #(PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops the expected release cycle and compares it
  always @(negedge clk) begin
    if (live) begin
      if (resume != '0) begin
        n_chk++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL R2: release at cycle %0d, expected none pending", cyc);
        end else begin
          int e;
          e = exp_q.pop_front();
          if (e != cyc) begin
            n_fail++;
            $display("FAIL %s: release cycle %0d, expected %0d", (cyc < e) ? "R2" : "R3", cyc, e);
          end
        end
        n_chk++;
        if (resume != '1) begin
          n_fail++;
          $display("FAIL R4: resume %b, expected all ones", resume);
        end
      end else if (exp_q.size() > 0 && exp_q[0] <= cyc) begin
        n_chk++; n_fail++;
        $display("FAIL R3: no release at cycle %0d, expected at %0d", cyc, exp_q.pop_front());
      end
    end
  end

  // mode 0 together, 1 one per cycle, 2 key core late, 3 random with repeats
  task automatic run_barrier(input int mode, input int key);
    int t_of[N];
    int last = 0;
    for (int i = 0; i < N; i++) begin
      case (mode)
        0: t_of[i] = 0;
        1: t_of[i] = N - 1 - i;
        2: t_of[i] = (i == key) ? 9 : 0;
        default: t_of[i] = int'($urandom_range(0, 6));
      endcase
      if (t_of[i] > last) last = t_of[i];
    end
    for (int t = 0; t <= last; t++) begin
      logic [N-1:0] a;
      a = '0;
      for (int i = 0; i < N; i++) begin
        if (t_of[i] == t) a[i] = 1'b1;
        else if (mode == 3 && t_of[i] < t && $urandom_range(0, 2) == 0) a[i] = 1'b1; // R6 repeats
      end
      arrive = a;
      if (t == last) exp_q.push_back(cyc + 4);   // R3: final arrival cycle + 4
      @(negedge clk);
    end
    arrive = '0;
    while (exp_q.size() > 0) @(negedge clk);      // R7: next barrier starts in the release cycle
  endtask

  initial begin
    repeat (3) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      n_chk++;
      if (resume != '0) begin n_fail++; $display("FAIL R1: resume %b in reset, expected 0", resume); end
      @(negedge clk);
    end
    rst_n = 1'b1;
    live = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      n_chk++;
      if (resume != '0) begin n_fail++; $display("FAIL R1: resume %b idle, expected 0", resume); end
    end
    run_barrier(0, 0);                 // R3 R4 R9 all together
    run_barrier(0, 0);                 // R7 back to back
    run_barrier(1, 0);                 // R5 one arrival per cycle
    run_barrier(2, 0);                 // R8 grid collector core last
    run_barrier(2, COLS);              // R8 row 1 collector last
    run_barrier(2, N - 1);             // R8 last slave of last row late
    run_barrier(2, 1);                 // R5 slave late in row 0
    for (int k = 0; k < 25; k++) run_barrier(3, 0);  // R5 R6 random order with repeats
    repeat (6) @(negedge clk);
    n_chk++;
    if (exp_q.size() != 0) begin n_fail++; $display("FAIL R3: %0d releases missing, expected 0", exp_q.size()); end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R3: watchdog expired at cycle %0d, expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule